// File: doc/BRIEF.md
# Three-Rail Power Sequencer

This block is a state machine that brings up a board with three supply rails in a fixed order. The main 5 V rail must be present and the shutdown request must be low before anything starts. The 3.3 V rail is then enabled, and the 2.5 V rail follows only once the 3.3 V rail reports good. The machine then rests in a power-good state until a rail drops or shutdown is requested.

Each enable step has a deadline counted in pulses of an external millisecond tick. A rail that misses its deadline is handled as a fault. If a rail drops after power-good is reached, two short sorting states test the rails one at a time. The machine then settles in one of two latched fault states, chosen by which rail dropped. A fault state holds its outputs until shutdown is requested. That request returns the machine to the first idle state.

All four level inputs (three supply-good flags and the shutdown request) pass through a two-stage synchronizer before the state logic uses them. Every output is a fixed function of the current state.

Top module: `pwr_seq3_top`

## Requirements
- R1: While reset is asserted, and on release, the state code is 0 (first idle) and the 3.3 V enable, the 2.5 V enable and the fault flag are all low.
- R2: The state code and the outputs {3.3 V enable, 2.5 V enable, fault} are: 0 wait-release=000, 1 wait-main=000, 2 ramp-3.3=100, 3 ramp-2.5=110, 4 power-good=110, 5 cut-3.3=011, 6 cut-2.5=101, 7 sort-1=111, 8 sort-2=111.
- R3: State 0 moves to state 1 only while the shutdown request is low. State 1 moves to state 2 only while it is low and the 5 V rail is good. State 1 returns to state 0 if the request is high.
- R4: A change on any of the four level inputs first affects the state at the third rising clock edge after it is applied (two synchronizer stages, then the state register).
- R5: State 2 moves to state 3 when the 3.3 V rail is good. State 3 moves to state 4 when the 2.5 V rail is good.
- R6: In state 2, once 10 tick pulses have been counted since entry without the 3.3 V rail good, the next clock edge enters state 5. After 9 pulses the state is still 2.
- R7: In state 3, once 20 tick pulses have been counted since entry without the 2.5 V rail good, the next clock edge enters state 6. After 19 pulses the state is still 3.
- R8: A high shutdown request in state 2, 3 or 4 sends the machine to state 0. This takes priority over every rail condition.
- R9: Loss of the 5 V rail in state 2 leads directly to state 5. In state 3, loss of the 5 V or the 3.3 V rail leads to state 7. In state 4, loss of any rail leads to state 7.
- R10: State 7 lasts one cycle and goes to state 5 if the 5 V rail is bad, otherwise to state 8. State 8 lasts one cycle and goes to state 5 if the 3.3 V rail is bad, otherwise to state 6.
- R11: States 5 and 6 hold while the shutdown request is low. They go to state 0 when it is high.
- R12: The tick count restarts from zero on every state entry, so pulses counted in state 2 do not shorten the deadline in state 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_ok_i | input | 1 | 5 V rail good (asynchronous) |
| rail_a_ok_i | input | 1 | 3.3 V rail good (asynchronous) |
| rail_b_ok_i | input | 1 | 2.5 V rail good (asynchronous) |
| off_req_i | input | 1 | Shutdown request, active high (asynchronous) |
| ms_tick_i | input | 1 | One-cycle millisecond pulse, synchronous to clk |
| en_3v3_o | output | 1 | 3.3 V rail enable |
| en_2v5_o | output | 1 | 2.5 V rail enable |
| fault_o | output | 1 | Fault flag |
| state_o | output | 4 | Current state code |

## Verification
A level-input change is applied at a falling edge. The resulting state, and the outputs decoded from it, are due just after the third rising edge. The bench checks one cycle early to confirm nothing moved, and then at exactly that edge. Tick pulses are registered directly, so the deadline transition is due one edge after the edge that counts the last pulse. The bench checks one pulse short of the limit and then on the due edge. The sorting states each last one cycle, and the bench samples them one edge apart, just after each rising edge.

// File: rtl/pwr_seq3_pkg.sv
package pwr_seq3_pkg;

  typedef enum logic [3:0] {
    ST_WAIT_CTL  = 4'd0,
    ST_WAIT_MAIN = 4'd1,
    ST_RAMP_A    = 4'd2,
    ST_RAMP_B    = 4'd3,
    ST_ON        = 4'd4,
    ST_CUT_A     = 4'd5,
    ST_CUT_B     = 4'd6,
    ST_SORT_1    = 4'd7,
    ST_SORT_2    = 4'd8
  } seq_state_e;

  typedef struct packed {
    logic en_a;
    logic en_b;
    logic flt;
  } drv_t;

  localparam int IN_W    = 4;
  localparam int IDX_MAIN = 0;
  localparam int IDX_A    = 1;
  localparam int IDX_B    = 2;
  localparam int IDX_OFF  = 3;

  // Fixed output pattern of every state
  function automatic drv_t drive_of(seq_state_e s);
    drv_t d;
    unique case (s)
      ST_WAIT_CTL, ST_WAIT_MAIN: d = '{en_a: 1'b0, en_b: 1'b0, flt: 1'b0};
      ST_RAMP_A:                 d = '{en_a: 1'b1, en_b: 1'b0, flt: 1'b0};
      ST_RAMP_B, ST_ON:          d = '{en_a: 1'b1, en_b: 1'b1, flt: 1'b0};
      ST_CUT_A:                  d = '{en_a: 1'b0, en_b: 1'b1, flt: 1'b1};
      ST_CUT_B:                  d = '{en_a: 1'b1, en_b: 1'b0, flt: 1'b1};
      ST_SORT_1, ST_SORT_2:      d = '{en_a: 1'b1, en_b: 1'b1, flt: 1'b1};
      default:                   d = '{en_a: 1'b0, en_b: 1'b0, flt: 1'b0};
    endcase
    return d;
  endfunction

  // Deadline reached when the counted pulses meet the limit
  function automatic logic limit_reached(logic [15:0] count, logic [15:0] limit);
    return count >= limit;
  endfunction

endpackage

// File: rtl/pwr_seq3_sync.sv
module pwr_seq3_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/pwr_seq3_tmr.sv
module pwr_seq3_tmr
  import pwr_seq3_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          expired_o
);

  logic [CW-1:0] cnt;

  assign expired_o = limit_reached(16'(cnt), 16'(limit_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart_i) begin
      cnt <= '0;
    end else if (tick_i && !expired_o) begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/pwr_seq3_fsm.sv
module pwr_seq3_fsm
  import pwr_seq3_pkg::*;
#(
  parameter int CW    = 5,
  parameter int LIM_A = 10,
  parameter int LIM_B = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          main_ok,
  input  logic          rail_a_ok,
  input  logic          rail_b_ok,
  input  logic          off_req,
  input  logic          expired_i,
  output seq_state_e    state_o,
  output logic          restart_o,
  output logic [CW-1:0] limit_o
);

  seq_state_e st, nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_WAIT_CTL: begin
        if (!off_req) nxt = ST_WAIT_MAIN;
      end
      ST_WAIT_MAIN: begin
        if (off_req)      nxt = ST_WAIT_CTL;
        else if (main_ok) nxt = ST_RAMP_A;
      end
      ST_RAMP_A: begin
        if (off_req)        nxt = ST_WAIT_CTL;
        else if (!main_ok)  nxt = ST_CUT_A;
        else if (rail_a_ok) nxt = ST_RAMP_B;
        else if (expired_i) nxt = ST_CUT_A;
      end
      ST_RAMP_B: begin
        if (off_req)                     nxt = ST_WAIT_CTL;
        else if (!(main_ok && rail_a_ok)) nxt = ST_SORT_1;
        else if (rail_b_ok)              nxt = ST_ON;
        else if (expired_i)              nxt = ST_CUT_B;
      end
      ST_ON: begin
        if (off_req)                                  nxt = ST_WAIT_CTL;
        else if (!(main_ok && rail_a_ok && rail_b_ok)) nxt = ST_SORT_1;
      end
      ST_SORT_1: nxt = main_ok ? ST_SORT_2 : ST_CUT_A;
      ST_SORT_2: nxt = rail_a_ok ? ST_CUT_B : ST_CUT_A;
      ST_CUT_A, ST_CUT_B: begin
        if (off_req) nxt = ST_WAIT_CTL;
      end
      default: nxt = ST_WAIT_CTL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_WAIT_CTL;
    else        st <= nxt;
  end

  assign state_o   = st;
  assign restart_o = (nxt != st);
  assign limit_o   = (st == ST_RAMP_B) ? CW'(LIM_B) : CW'(LIM_A);

endmodule

// File: rtl/pwr_seq3_top.sv
module pwr_seq3_top
  import pwr_seq3_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TMO_A_MS    = 10,
  parameter int TMO_B_MS    = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       main_ok_i,
  input  logic       rail_a_ok_i,
  input  logic       rail_b_ok_i,
  input  logic       off_req_i,
  input  logic       ms_tick_i,
  output logic       en_3v3_o,
  output logic       en_2v5_o,
  output logic       fault_o,
  output logic [3:0] state_o
);

  localparam int TMO_MAX = (TMO_A_MS > TMO_B_MS) ? TMO_A_MS : TMO_B_MS;
  localparam int CW      = $clog2(TMO_MAX + 1);
  localparam logic [IN_W-1:0] SYNC_RST = IN_W'(1) << IDX_OFF;

  logic [IN_W-1:0] raw_in, sync_q;
  logic            main_ok_s, rail_a_ok_s, rail_b_ok_s, off_req_s;
  logic            tmo_hit, tmr_restart;
  logic [CW-1:0]   tmr_limit;
  seq_state_e      cur_st;
  drv_t            drv;

  always_comb begin
    raw_in          = '0;
    raw_in[IDX_MAIN] = main_ok_i;
    raw_in[IDX_A]    = rail_a_ok_i;
    raw_in[IDX_B]    = rail_b_ok_i;
    raw_in[IDX_OFF]  = off_req_i;
  end

  pwr_seq3_sync #(
    .W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(sync_q)
  );

  assign main_ok_s   = sync_q[IDX_MAIN];
  assign rail_a_ok_s = sync_q[IDX_A];
  assign rail_b_ok_s = sync_q[IDX_B];
  assign off_req_s   = sync_q[IDX_OFF];

  pwr_seq3_tmr #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart_i(tmr_restart), .tick_i(ms_tick_i),
    .limit_i(tmr_limit), .expired_o(tmo_hit)
  );

  pwr_seq3_fsm #(.CW(CW), .LIM_A(TMO_A_MS), .LIM_B(TMO_B_MS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .main_ok(main_ok_s), .rail_a_ok(rail_a_ok_s),
    .rail_b_ok(rail_b_ok_s), .off_req(off_req_s), .expired_i(tmo_hit),
    .state_o(cur_st), .restart_o(tmr_restart), .limit_o(tmr_limit)
  );

  assign drv      = drive_of(cur_st);
  assign en_3v3_o = drv.en_a;
  assign en_2v5_o = drv.en_b;
  assign fault_o  = drv.flt;
  assign state_o  = cur_st;

endmodule

// File: rtl/pwr_seq3_chk.sv
module pwr_seq3_chk
  import pwr_seq3_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] state_o,
  input logic       en_3v3_o,
  input logic       en_2v5_o,
  input logic       fault_o,
  input logic       main_ok_s,
  input logic       rail_a_ok_s,
  input logic       off_req_s,
  input logic       tmo_hit
);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_WAIT_CTL || state_o == ST_WAIT_MAIN) |-> (!en_3v3_o && !en_2v5_o && !fault_o));

  // R2
  fault_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (state_o >= 4'd5 && state_o <= 4'd8));

  // R3
  ramp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_RAMP_A && $past(state_o) != ST_RAMP_A) |-> ($past(state_o) == ST_WAIT_MAIN && $past(main_ok_s)));

  // R5
  on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_ON && $past(state_o) != ST_ON) |-> ($past(state_o) == ST_RAMP_B));

  // R6
  tmo_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_RAMP_A && tmo_hit && !off_req_s && main_ok_s && !rail_a_ok_s) |=> (state_o == ST_CUT_A));

  // R8
  off_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == ST_RAMP_A || state_o == ST_RAMP_B || state_o == ST_ON) && off_req_s) |=> (state_o == ST_WAIT_CTL));

  // R10
  sort_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_SORT_2) |-> ($past(state_o) == ST_SORT_1));

  // R11
  cut_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == ST_CUT_A || state_o == ST_CUT_B) && !off_req_s) |=> $stable(state_o));

endmodule

bind pwr_seq3_top pwr_seq3_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state_o(state_o), .en_3v3_o(en_3v3_o),
  .en_2v5_o(en_2v5_o), .fault_o(fault_o), .main_ok_s(main_ok_s),
  .rail_a_ok_s(rail_a_ok_s), .off_req_s(off_req_s), .tmo_hit(tmo_hit)
);

// File: tb/pwr_seq3_top_tb.sv
module pwr_seq3_top_tb;

  localparam int S_WC = 0, S_WM = 1, S_RA = 2, S_RB = 3, S_ON = 4,
                 S_CA = 5, S_CB = 6, S_S1 = 7, S_S2 = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m = 1'b0, a = 1'b0, b = 1'b0, off = 1'b1, tick = 1'b0;
  logic en33, en25, flt;
  logic [3:0] st;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_seq3_top u_dut (
    .clk(clk), .rst_n(rst_n), .main_ok_i(m), .rail_a_ok_i(a), .rail_b_ok_i(b),
    .off_req_i(off), .ms_tick_i(tick), .en_3v3_o(en33), .en_2v5_o(en25),
    .fault_o(flt), .state_o(st)
  );

  // Output triple expected for a state code, derived from the R2 table
  function automatic logic [2:0] exp_out(int code);
    logic e33, e25, f;
    f   = (code >= 5);
    e33 = (code >= 2 && code <= 4) || code == 6 || code == 7 || code == 8;
    e25 = (code == 3) || (code == 4) || (code == 5) || (code >= 7);
    return {e33, e25, f};
  endfunction

  task automatic expect_st(int code, string tag);
    total++;
    if (st != 4'(code)) begin
      bad++;
      $display("FAIL %s state actual=%0d expected=%0d", tag, st, code);
    end
    total++;
    if ({en33, en25, flt} != exp_out(code)) begin
      bad++;
      $display("FAIL %s outputs actual=%b expected=%b", tag, {en33, en25, flt}, exp_out(code));
    end
  endtask

  task automatic drive(logic nm, logic na, logic nb, logic noff);
    @(negedge clk);
    m = nm; a = na; b = nb; off = noff;
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  // From state 0 with shutdown high: release with every rail good
  task automatic full_up(string tag);
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    step(3); expect_st(S_WM, tag);
    step(1); expect_st(S_RA, tag);
    step(1); expect_st(S_RB, tag);
    step(1); expect_st(S_ON, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    step(3);
    expect_st(S_WC, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    step(5);
    expect_st(S_WC, "R1 after release, R3 held by shutdown");

    // R3 / R4: release shutdown
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    step(2); expect_st(S_WC, "R4 two edges no change");
    step(1); expect_st(S_WM, "R3 R4 enter wait-main");
    step(6); expect_st(S_WM, "R3 no start without 5V");
    drive(1'b0, 1'b0, 1'b0, 1'b1);
    step(3); expect_st(S_WC, "R3 wait-main back on shutdown");
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    step(3); expect_st(S_WM, "R3 wait-main again");

    // R5 / R6: start, 3.3 V deadline
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    step(3); expect_st(S_RA, "R5 ramp-3.3 entry");
    ticks(9); expect_st(S_RA, "R6 nine pulses");
    step(1);  expect_st(S_RA, "R6 nine pulses later");
    ticks(1); step(1); expect_st(S_CA, "R6 deadline cut-3.3");
    step(8);  expect_st(S_CA, "R11 cut-3.3 hold");
    drive(1'b1, 1'b0, 1'b0, 1'b1);
    step(3); expect_st(S_WC, "R11 cut-3.3 to idle");

    // R12 / R7: restart of count and 2.5 V deadline
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    step(3); expect_st(S_WM, "R3 wait-main");
    step(1); expect_st(S_RA, "R4 ramp-3.3 one edge later");
    ticks(5);
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    step(3); expect_st(S_RB, "R5 ramp-2.5 entry");
    ticks(19); expect_st(S_RB, "R12 R7 nineteen pulses");
    step(1);   expect_st(S_RB, "R7 nineteen pulses later");
    ticks(1); step(1); expect_st(S_CB, "R7 deadline cut-2.5");
    step(5); expect_st(S_CB, "R11 cut-2.5 hold");
    drive(1'b1, 1'b1, 1'b0, 1'b1);
    step(3); expect_st(S_WC, "R11 cut-2.5 to idle");

    // R5 full power-up, then 2.5 V loss
    full_up("R5 power-up");
    step(10); expect_st(S_ON, "R5 power-good hold");
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    step(2); expect_st(S_ON, "R4 fault not yet seen");
    step(1); expect_st(S_S1, "R9 sort-1 on 2.5 loss");
    step(1); expect_st(S_S2, "R10 sort-2");
    step(1); expect_st(S_CB, "R10 2.5 loss to cut-2.5");
    drive(1'b1, 1'b1, 1'b0, 1'b1);
    step(3); expect_st(S_WC, "R11 idle");

    // 3.3 V loss from power-good
    full_up("R5 power-up 2");
    drive(1'b1, 1'b0, 1'b1, 1'b0);
    step(3); expect_st(S_S1, "R9 sort-1 on 3.3 loss");
    step(1); expect_st(S_S2, "R10 sort-2 3.3");
    step(1); expect_st(S_CA, "R10 3.3 loss to cut-3.3");
    drive(1'b1, 1'b0, 1'b1, 1'b1);
    step(3); expect_st(S_WC, "R11 idle 2");

    // 5 V loss from power-good
    full_up("R5 power-up 3");
    drive(1'b0, 1'b1, 1'b1, 1'b0);
    step(3); expect_st(S_S1, "R9 sort-1 on 5V loss");
    step(1); expect_st(S_CA, "R10 5V loss to cut-3.3");
    drive(1'b0, 1'b1, 1'b1, 1'b1);
    step(3); expect_st(S_WC, "R11 idle 3");

    // R8 shutdown wins over a simultaneous rail loss
    full_up("R5 power-up 4");
    drive(1'b1, 1'b1, 1'b0, 1'b1);
    step(3); expect_st(S_WC, "R8 shutdown priority in power-good");

    // 3.3 V loss during ramp-2.5
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    step(3); expect_st(S_WM, "R3 wait-main 5");
    step(2); expect_st(S_RB, "R5 ramp-2.5 5");
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    step(3); expect_st(S_S1, "R9 ramp-2.5 3.3 loss");
    step(1); expect_st(S_S2, "R10 sort-2 ramp");
    step(1); expect_st(S_CA, "R10 cut-3.3 ramp");
    drive(1'b1, 1'b1, 1'b0, 1'b1);
    step(3); expect_st(S_WC, "R11 idle 5");

    // 5 V loss during ramp-2.5
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    step(5); expect_st(S_RB, "R5 ramp-2.5 6");
    drive(1'b0, 1'b1, 1'b0, 1'b0);
    step(3); expect_st(S_S1, "R9 ramp-2.5 5V loss");
    step(1); expect_st(S_CA, "R10 cut-3.3 on 5V");
    drive(1'b1, 1'b0, 1'b0, 1'b1);
    step(3); expect_st(S_WC, "R11 idle 6");

    // 5 V loss during ramp-3.3, then shutdown during ramp-3.3
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    step(4); expect_st(S_RA, "R5 ramp-3.3 7");
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    step(3); expect_st(S_CA, "R9 ramp-3.3 5V loss direct");
    drive(1'b1, 1'b0, 1'b0, 1'b1);
    step(3); expect_st(S_WC, "R11 idle 7");
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    step(4); expect_st(S_RA, "R5 ramp-3.3 8");
    drive(1'b1, 1'b0, 1'b0, 1'b1);
    step(3); expect_st(S_WC, "R8 shutdown in ramp-3.3");

    // shutdown during ramp-2.5
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    step(5); expect_st(S_RB, "R5 ramp-2.5 9");
    drive(1'b1, 1'b1, 1'b0, 1'b1);
    step(3); expect_st(S_WC, "R8 shutdown in ramp-2.5");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule